// File: doc/BRIEF.md
# Converter Sequencer with Idle Power-Down

This block sequences an on-chip analog-to-digital converter from a small register interface. Software writes a control byte that holds a start flag, a 4-bit input channel, a mode flag and two reference-configuration flags. A second byte holds the remaining reference-select flag. A start request is accepted only when the sequencer is idle or powered down. The sequencer then latches the channel, applies analog power if needed, times the conversion and strobes the analog front end in the conversion's final cycle. It captures the 11-bit two's-complement sample into two byte-wide data registers.

When the converter has been idle for a fixed run of cycles, the block removes analog power by itself. Only a new start request brings it back, and that request pays a fixed warm-up delay before its conversion begins. Only single-shot operation is modelled (mode flag 0). After each conversion the sequencer returns to idle and restarts its idle count from zero.

Register map, with address on `wrAddr`/`rdAddr`:
- Address 0 (control A) holds: bit 0 start/busy, bit 1 mode, bit 2 reference-output request, bit 3 reference select low, bits [7:4] channel.
- Address 1 (control B) holds bit 0, reference select high; the other bits read 0.
- Address 2 holds the result high byte.
- Address 3 holds the result low bits.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `powerEn` is 0, `sampleStrobe` is 0, and every register reads 0 on `rdData`.
- R2: A start request (write to address 0 with bit 0 set) accepted while powered down raises `powerEn` at the accepting edge. Completion, meaning the result load, happens exactly 40 + 5129 = 5169 clock edges after the accepting edge.
- R3: A start request accepted while idle and powered completes exactly 5129 edges after the accepting edge, with no warm-up.
- R4: Address 0 bit 0 reads 1 from the accepting edge until the completion edge and reads 0 afterwards. Address 0 bits [7:1] read back the last value written.
- R5: `powerEn` falls at the 160th edge after completion if no request arrives in between. A request accepted at that same 160th edge wins: power stays on and the conversion takes 5129 edges.
- R6: No write other than a start request raises `powerEn`.
- R7: At completion the sample's bits [10:3] load into address 2 and its bits [2:0] into address 3 bits [7:5]. Address 3 bits [4:0] read 0. Both registers change in the same edge and at no other time.
- R8: `chanSel` takes the channel field at the accepting edge and holds it for the whole conversion, even if address 0 is rewritten.
- R9: `refDrive` equals the reference-output request bit ANDed with the OR of the two reference-select bits. Select value 00 means the internal reference is off.
- R10: A start request made while a conversion or warm-up is running is ignored. It neither restarts nor lengthens the operation.
- R11: `sampleStrobe` is high for exactly one cycle per conversion, the last cycle before completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| sampleIn | input | 11 | Sample presented by the analog front end |
| sampleStrobe | output | 1 | Front-end sample strobe, last conversion cycle |
| chanSel | output | 4 | Latched input channel |
| powerEn | output | 1 | Analog power enable |
| refDrive | output | 1 | Reference output drive enable |

## Verification
Two functions can meet in one clock edge: the idle timer expiring and a start request being accepted. The bench waits until 159 idle edges have passed since completion. It then drives a start request so that the request is sampled at the very edge that would otherwise power the converter down. The reference model gives priority to the request, so `powerEn` must stay high on every following cycle and the measured latency must be 5129 edges, not 5169. A second contest, a repeated start request landing mid-conversion, is judged by that conversion's latency and its latched channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CH_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_CTLA = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CTLB = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd3;

  localparam int BIT_START  = 0;
  localparam int BIT_MODE   = 1;
  localparam int BIT_REFOUT = 2;
  localparam int BIT_REFLO  = 3;
  localparam int CH_LSB     = 4;
  localparam int BIT_REFHI  = 0;

  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_WAKE = 2'd1,
    PH_IDLE = 2'd2,
    PH_CONV = 2'd3
  } phase_e;

  typedef struct packed {
    logic latchChan;
    logic loadResult;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int IDLE_LIMIT  = 160,
  parameter int WAKE_CYCLES = 40,
  parameter int CONV_CYCLES = 5129
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output seqStrobe_t strobes,
  output logic       busy,
  output logic       powerEn,
  output logic       sampleStrobe
);

  localparam int PH_MAX = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [PH_W-1:0]   CONV_LAST = PH_W'(CONV_CYCLES - 1);
  localparam logic [PH_W-1:0]   WAKE_LAST = PH_W'(WAKE_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);

  phase_e            phase;
  logic [PH_W-1:0]   phaseCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              convDone;
  logic              wakeDone;
  logic              acceptReq;

  always_comb begin
    convDone  = (phase == PH_CONV) && (phaseCnt == CONV_LAST);
    wakeDone  = (phase == PH_WAKE) && (phaseCnt == WAKE_LAST);
    acceptReq = startReq && ((phase == PH_DOWN) || (phase == PH_IDLE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_DOWN;
      phaseCnt <= '0;
      idleCnt  <= '0;
    end else begin
      unique case (phase)
        PH_DOWN: begin
          if (startReq) begin
            phase    <= PH_WAKE;
            phaseCnt <= '0;
          end
        end
        PH_WAKE: begin
          if (wakeDone) begin
            phase    <= PH_CONV;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_IDLE: begin
          if (startReq) begin
            phase    <= PH_CONV;
            phaseCnt <= '0;
          end else if (idleCnt == IDLE_LAST) begin
            phase   <= PH_DOWN;
            idleCnt <= '0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        PH_CONV: begin
          if (convDone) begin
            phase   <= PH_IDLE;
            idleCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: phase <= PH_DOWN;
      endcase
    end
  end

  always_comb begin
    busy               = (phase == PH_WAKE) || (phase == PH_CONV);
    powerEn            = (phase != PH_DOWN);
    sampleStrobe       = convDone;
    strobes.latchChan  = acceptReq;
    strobes.loadResult = convDone;
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [RES_W-1:0]  sampleIn,
  input  seqStrobe_t        strobes,
  input  logic              busy,
  output logic              startReq,
  output logic [CH_W-1:0]   chanSel,
  output logic              refDrive,
  output logic [DATA_W-1:0] dataHi,
  output logic [DATA_W-1:0] dataLo
);

  localparam int LO_BITS = RES_W - DATA_W;
  localparam int LO_PAD  = DATA_W - LO_BITS;

  logic [CH_W-1:0]    chanField;
  logic               modeBit;
  logic               refOutReq;
  logic               refSelLo;
  logic               refSelHi;
  logic [DATA_W-1:0]  resHi;
  logic [LO_BITS-1:0] resLo;
  logic               wrCtlA;
  logic               wrCtlB;

  always_comb begin
    wrCtlA   = wrEn && (wrAddr == ADR_CTLA);
    wrCtlB   = wrEn && (wrAddr == ADR_CTLB);
    startReq = wrCtlA && wrData[BIT_START];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanField <= '0;
      modeBit   <= 1'b0;
      refOutReq <= 1'b0;
      refSelLo  <= 1'b0;
      refSelHi  <= 1'b0;
    end else begin
      if (wrCtlA) begin
        chanField <= wrData[CH_LSB +: CH_W];
        modeBit   <= wrData[BIT_MODE];
        refOutReq <= wrData[BIT_REFOUT];
        refSelLo  <= wrData[BIT_REFLO];
      end
      if (wrCtlB) begin
        refSelHi <= wrData[BIT_REFHI];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel <= '0;
    end else if (strobes.latchChan) begin
      chanSel <= wrData[CH_LSB +: CH_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHi <= '0;
      resLo <= '0;
    end else if (strobes.loadResult) begin
      resHi <= sampleIn[RES_W-1 -: DATA_W];
      resLo <= sampleIn[LO_BITS-1:0];
    end
  end

  always_comb begin
    refDrive = refOutReq && (refSelHi || refSelLo);
    dataHi   = resHi;
    dataLo   = {resLo, {LO_PAD{1'b0}}};
  end

  always_comb begin
    unique case (rdAddr)
      ADR_CTLA: rdData = {chanField, refSelLo, refOutReq, modeBit, busy};
      ADR_CTLB: rdData = {{(DATA_W-1){1'b0}}, refSelHi};
      ADR_HI:   rdData = dataHi;
      default:  rdData = dataLo;
    endcase
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int IDLE_LIMIT  = 160,
  parameter int WAKE_CYCLES = 40,
  parameter int CONV_CYCLES = 5129,
  parameter int RES_W       = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [1:0]        rdAddr,
  output logic [7:0]        rdData,
  input  logic [RES_W-1:0]  sampleIn,
  output logic              sampleStrobe,
  output logic [3:0]        chanSel,
  output logic              powerEn,
  output logic              refDrive
);

  seqStrobe_t        strobes;
  logic              busy;
  logic              startReq;
  logic [DATA_W-1:0] dataHi;
  logic [DATA_W-1:0] dataLo;

  adc_seq_ctrl #(
    .IDLE_LIMIT (IDLE_LIMIT),
    .WAKE_CYCLES(WAKE_CYCLES),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .strobes     (strobes),
    .busy        (busy),
    .powerEn     (powerEn),
    .sampleStrobe(sampleStrobe)
  );

  adc_seq_dp #(
    .RES_W(RES_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .sampleIn(sampleIn),
    .strobes (strobes),
    .busy    (busy),
    .startReq(startReq),
    .chanSel (chanSel),
    .refDrive(refDrive),
    .dataHi  (dataHi),
    .dataLo  (dataLo)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sampleStrobe,
  input logic       powerEn,
  input logic       busy,
  input logic       startReq,
  input logic [3:0] chanSel,
  input logic [7:0] dataHi,
  input logic [7:0] dataLo
);

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R2
  strobe_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> powerEn);

  // R4
  busy_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !busy);

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(chanSel));

  // R6
  wake_by_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> $past(startReq));

  // R7
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStrobe) |-> ($stable(dataHi) && $stable(dataLo)));

  // R5
  powerdown_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerEn) |-> !$past(busy));

endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleStrobe(sampleStrobe),
  .powerEn     (powerEn),
  .busy        (busy),
  .startReq    (startReq),
  .chanSel     (chanSel),
  .dataHi      (dataHi),
  .dataLo      (dataLo)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [7:0]  rdData;
  logic [10:0] sampleIn = 11'd0;
  logic        sampleStrobe;
  logic [3:0]  chanSel;
  logic        powerEn;
  logic        refDrive;

  always #10 clk = ~clk;

  adc_seq_top u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .sampleIn    (sampleIn),
    .sampleStrobe(sampleStrobe),
    .chanSel     (chanSel),
    .powerEn     (powerEn),
    .refDrive    (refDrive)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cycleNo = 0;
  bit done    = 0;

  // behavioural reference: 0 down, 1 warm-up, 2 idle, 3 converting
  int mPhase = 0;
  int mCnt = 0;
  int mIdle = 0;
  int reqEdge = 0;
  int expLat = 0;
  logic [3:0] mChanField = 0, mChan = 0;
  logic mMode = 0, mRefOut = 0, mRefLo = 0, mRefHi = 0;
  logic [10:0] mRes = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mIdle = 0;
      mChanField = 0; mChan = 0; mMode = 0; mRefOut = 0; mRefLo = 0; mRefHi = 0;
      mRes = 0;
    end else begin
      bit req;
      cycleNo++;
      req = wrEn && wrAddr == 2'd0 && wrData[0];
      if (mPhase == 0) begin
        if (req) begin mPhase = 1; mCnt = 0; mChan = wrData[7:4]; reqEdge = cycleNo; expLat = 40 + 5129; end
      end else if (mPhase == 1) begin
        mCnt++;
        if (mCnt == 40) begin mPhase = 3; mCnt = 0; end
      end else if (mPhase == 2) begin
        if (req) begin mPhase = 3; mCnt = 0; mChan = wrData[7:4]; reqEdge = cycleNo; expLat = 5129; end
        else begin
          mIdle++;
          if (mIdle == 160) mPhase = 0;
        end
      end else begin
        mCnt++;
        if (mCnt == 5129) begin mRes = sampleIn; mPhase = 2; mIdle = 0; end
      end
      if (wrEn && wrAddr == 2'd0) begin
        mChanField = wrData[7:4]; mMode = wrData[1]; mRefOut = wrData[2]; mRefLo = wrData[3];
      end
      if (wrEn && wrAddr == 2'd1) mRefHi = wrData[0];
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expRd;
      bit busyM;
      busyM = (mPhase == 1) || (mPhase == 3);
      chk("R5 R2 powerEn", powerEn, mPhase != 0);
      chk("R11 sampleStrobe", sampleStrobe, (mPhase == 3) && (mCnt == 5128));
      chk("R8 chanSel", chanSel, mChan);
      chk("R9 refDrive", refDrive, mRefOut & (mRefHi | mRefLo));
      case (rdAddr)
        2'd0: expRd = {mChanField, mRefLo, mRefOut, mMode, busyM};
        2'd1: expRd = {7'd0, mRefHi};
        2'd2: expRd = mRes[10:3];
        default: expRd = {mRes[2:0], 5'd0};
      endcase
      if (rdAddr == 2'd0)      chk("R4 control readback", rdData, expRd);
      else if (rdAddr == 2'd1) chk("R9 control B readback", rdData, expRd);
      else                     chk("R7 result readback", rdData, expRd);
      if (sampleStrobe) chk("R2 R3 R10 latency", cycleNo + 1 - reqEdge, expLat);
      rdAddr <= rdAddr + 2'd1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'd0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 powerEn", powerEn, 0);
    chk("R1 sampleStrobe", sampleStrobe, 0);
    chk("R1 rdData", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reference drive needs an enabled internal reference
    wr(2'd0, 8'b0000_0100);
    chk("R9 refDrive select off", refDrive, 0);
    wr(2'd0, 8'b0000_1100);
    chk("R9 refDrive select on", refDrive, 1);
    wr(2'd1, 8'h01);
    // R6: no start request, power stays off
    repeat (5) @(negedge clk);
    chk("R6 powerEn after plain writes", powerEn, 0);
    // R2: request from power-down, channel 5, negative sample
    sampleIn = 11'h5A3;
    wr(2'd0, 8'b0101_0001);
    chk("R2 powerEn raised", powerEn, 1);
    repeat (100) @(negedge clk);
    // R10 R8: repeated request with other channel is ignored
    wr(2'd0, 8'b1001_0001);
    chk("R8 channel held", chanSel, 4'd5);
    while (!(mPhase == 2 && mIdle == 159)) @(negedge clk);
    // R5: request lands on the power-down edge
    sampleIn = 11'h0F0;
    wr(2'd0, 8'b0011_0001);
    chk("R5 boundary request keeps power", powerEn, 1);
    while (mPhase != 2) @(negedge clk);
    repeat (170) @(negedge clk);
    chk("R5 idle power-down", powerEn, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'b0000_0000);
    chk("R6 still down", powerEn, 0);
    // R3 path after a fresh wake; result positive
    sampleIn = 11'h3FF;
    wr(2'd0, 8'b1111_0001);
    while (mPhase != 2) @(negedge clk);
    sampleIn = 11'h2C5;
    @(negedge clk);
    wr(2'd0, 8'b0110_0001);
    while (mPhase != 2) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R7 low pad bits", {rdAddr == 2'd3 ? rdData[4:0] : 5'd0}, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule